// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steps a small processor subsystem through four power states: run, light sleep, deep sleep and hibernate. A wait-for-interrupt strobe from the core starts a sleep. A deep-select bit in the control register, sampled on that strobe, picks the depth. In either sleep the core and memory clock enables drop, and the peripheral enables keep their run values. Deep sleep can also move the peripherals to a slower clock source. Any pending interrupt brings the system back to run on the next cycle.

Software enters hibernate by writing a request bit. All clock enables drop first, and one cycle later a regulator-off output tells the external supply to shut down. Only the always-on section keeps running. It holds a seconds counter with a compare register, the flags for low battery and counter match, a wake-status register and sixteen retained 32-bit words. An enabled external wake pin, a counter-match flag or a low-battery flag ends hibernate. The controller then waits a programmable number of cycles before it releases the regulator and restores the clocks.

The whole register file sits in the always-on domain, so software can access it in every state. The state code is exported as `pwr_state_o`.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset the state code is 0 (run), the core, memory and system clock enables are 1, all peripheral enables are 1, and regulator-off and irq are 0.
- R2: A `wfi_i` pulse in run with no wake pending moves the state to 1 (sleep) when control bit 2 is clear, or to 2 (deep sleep) when it is set. Bit 2 is sampled in the cycle of the pulse. Both sleeps clear the core and memory enables and keep the system enable at 1.
- R3: In run, sleep and deep sleep, `periph_clk_en_o` equals the peripheral-enable register (address 1, reset all ones). `periph_slow_o` is 1 only in deep sleep, and only when control bit 1 (auto gating) is set.
- R4: In sleep or deep sleep, `irq_pend_i` or `irq_o` returns the state to run on the next edge, with all enables restored. A `wfi_i` in the same cycle as a pending wake leaves the state in run.
- R5: Writing 1 to control bit 0 in run enters state 3. In state 3 every clock and peripheral enable is 0 and regulator-off is still 0. The next edge enters state 4 (hibernate), where regulator-off is 1. Control bit 0 always reads back as 0.
- R6: In hibernate, each of these moves the state to 5 (wake wait): `ext_wake_i` when control bit 4 is set, the counter-match flag when control bit 5 is set, and the low-battery flag.
- R7: State 5 lasts DELAY+1 cycles, where DELAY is the register at address 6. Regulator-off stays 1 and the clocks stay off during that time. Regulator-off falls on the same edge that returns the state to run with all clocks on.
- R8: The wake-status register at address 4 records the sources active at the wake edge: bit 0 external, bit 1 counter match, bit 2 low battery. Writing 1 to a bit clears it.
- R9: The counter at address 2 increments on each `sec_tick_i` pulse, and a write loads it. The match flag (address 5, bit 0) sets on the tick that brings the counter to the compare value at address 3. The flag holds until software writes 1 to it. `irq_o` is the OR of the flags.
- R10: `low_bat_i` sets the low-battery flag (address 5, bit 1) only when control bit 3 is set. When the bit is clear, `low_bat_i` is ignored.
- R11: Addresses 16 to 31 are retained words. They can be read and written in every state, including hibernate, and their contents survive a hibernate cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-on clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 5 | register address |
| reg_wdata_i | input | 32 | write data |
| reg_rdata_o | output | 32 | read data (combinational) |
| wfi_i | input | 1 | wait-for-interrupt strobe from the core |
| irq_pend_i | input | 1 | enabled interrupt pending at the core |
| ext_wake_i | input | 1 | external wake pin |
| low_bat_i | input | 1 | low-battery detect |
| sec_tick_i | input | 1 | one-cycle seconds tick |
| core_clk_en_o | output | 1 | core clock enable |
| mem_clk_en_o | output | 1 | memory clock enable |
| sys_clk_en_o | output | 1 | system clock enable |
| periph_clk_en_o | output | 8 | per-peripheral clock enables |
| periph_slow_o | output | 1 | select reduced-rate peripheral clock |
| reg_off_o | output | 1 | external regulator off request |
| irq_o | output | 1 | always-on interrupt |
| pwr_state_o | output | 3 | current power state code |

## Verification
The sleep-entry strobe and a wake condition can arrive in the same cycle. The bench raises `wfi_i` and `irq_pend_i` together at one falling edge and expects the state code to read run after the next edge, with no sleep cycle in between. A second overlap is a counter tick that lands while the controller is in hibernate. There the bench expects the match flag to show first and the wake-wait state to follow one cycle later.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int REG_AW = 5;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SLEEP    = 3'd1,
    ST_DSLEEP   = 3'd2,
    ST_HIB_ENT  = 3'd3,
    ST_HIB      = 3'd4,
    ST_HIB_WAKE = 3'd5
  } pwr_state_e;

  localparam logic [REG_AW-1:0] A_CTRL   = 5'd0;
  localparam logic [REG_AW-1:0] A_PERIPH = 5'd1;
  localparam logic [REG_AW-1:0] A_RTC    = 5'd2;
  localparam logic [REG_AW-1:0] A_MATCH  = 5'd3;
  localparam logic [REG_AW-1:0] A_WSTAT  = 5'd4;
  localparam logic [REG_AW-1:0] A_IRQ    = 5'd5;
  localparam logic [REG_AW-1:0] A_DELAY  = 5'd6;

  localparam int C_HIB_REQ = 0;
  localparam int C_AUTO_GT = 1;
  localparam int C_DEEP    = 2;
  localparam int C_LBAT_EN = 3;
  localparam int C_EXT_EN  = 4;
  localparam int C_RTC_EN  = 5;
  localparam int CTRL_W    = 6;

  typedef struct packed {
    logic lbat;
    logic rtc;
    logic ext;
  } wake_src_t;
endpackage

// File: rtl/lpm_rtc.sv
module lpm_rtc #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             match_we_i,
  input  logic [CNT_W-1:0] match_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] match_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, match_q, cnt_inc;
  logic             flag_q, hit;

  assign cnt_inc = cnt_q + ONE;
  assign hit     = tick_i && !load_i && (cnt_inc == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= '1;
      flag_q  <= 1'b0;
    end else begin
      if (load_i)      cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_inc;
      if (match_we_i)  match_q <= match_val_i;
      if (hit)         flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/lpm_retmem.sv
module lpm_retmem #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))    mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wfi_i,
  input  logic             deep_sel_i,
  input  logic             hib_req_i,
  input  logic             sleep_wake_i,
  input  logic             hib_wake_i,
  input  logic [DLY_W-1:0] dly_i,
  output pwr_state_e       state_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  pwr_state_e       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (hib_req_i)                   st_d = ST_HIB_ENT;
        else if (wfi_i && !sleep_wake_i) st_d = deep_sel_i ? ST_DSLEEP : ST_SLEEP;
      end
      ST_SLEEP, ST_DSLEEP: if (sleep_wake_i) st_d = ST_RUN;
      ST_HIB_ENT: st_d = ST_HIB;
      ST_HIB: begin
        if (hib_wake_i) begin
          st_d  = ST_HIB_WAKE;
          cnt_d = dly_i;
        end
      end
      ST_HIB_WAKE: begin
        if (cnt_q == '0) st_d  = ST_RUN;
        else             cnt_d = cnt_q - ONE;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int NPERIPH   = 8,
  parameter int RET_WORDS = 16,
  parameter int DLY_W     = 8,
  parameter int DW        = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               wfi_i,
  input  logic               irq_pend_i,
  input  logic               ext_wake_i,
  input  logic               low_bat_i,
  input  logic               sec_tick_i,
  output logic               core_clk_en_o,
  output logic               mem_clk_en_o,
  output logic               sys_clk_en_o,
  output logic [NPERIPH-1:0] periph_clk_en_o,
  output logic               periph_slow_o,
  output logic               reg_off_o,
  output logic               irq_o,
  output logic [2:0]         pwr_state_o
);
  localparam int RET_AW = $clog2(RET_WORDS);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [NPERIPH-1:0] periph_q;
  logic [DLY_W-1:0]   dly_q;
  wake_src_t          wstat_q, wsrc;
  logic               lbat_q;
  logic               rtc_flag;
  logic [DW-1:0]      rtc_cnt, rtc_match, ret_rdata;
  pwr_state_e         state;

  logic wr_ctrl, wr_periph, wr_rtc, wr_match, wr_wstat, wr_irq, wr_dly, wr_ret;
  logic hib_req, hib_wake, sleep_wake, awake;

  assign wr_ctrl   = reg_we_i && reg_addr_i == A_CTRL;
  assign wr_periph = reg_we_i && reg_addr_i == A_PERIPH;
  assign wr_rtc    = reg_we_i && reg_addr_i == A_RTC;
  assign wr_match  = reg_we_i && reg_addr_i == A_MATCH;
  assign wr_wstat  = reg_we_i && reg_addr_i == A_WSTAT;
  assign wr_irq    = reg_we_i && reg_addr_i == A_IRQ;
  assign wr_dly    = reg_we_i && reg_addr_i == A_DELAY;
  assign wr_ret    = reg_we_i && reg_addr_i[REG_AW-1];

  assign hib_req = wr_ctrl && reg_wdata_i[C_HIB_REQ];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      periph_q <= '1;
      dly_q    <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= {reg_wdata_i[CTRL_W-1:1], 1'b0};
      if (wr_periph) periph_q <= reg_wdata_i[NPERIPH-1:0];
      if (wr_dly)    dly_q    <= reg_wdata_i[DLY_W-1:0];
    end
  end

  lpm_rtc #(.CNT_W(DW)) u_rtc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (sec_tick_i),
    .load_i     (wr_rtc),
    .load_val_i (reg_wdata_i),
    .match_we_i (wr_match),
    .match_val_i(reg_wdata_i),
    .clr_i      (wr_irq && reg_wdata_i[0]),
    .cnt_o      (rtc_cnt),
    .match_o    (rtc_match),
    .flag_o     (rtc_flag)
  );

  // low-battery flag: set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               lbat_q <= 1'b0;
    else if (ctrl_q[C_LBAT_EN] && low_bat_i)   lbat_q <= 1'b1;
    else if (wr_irq && reg_wdata_i[1])         lbat_q <= 1'b0;
  end

  assign irq_o      = rtc_flag | lbat_q;
  assign sleep_wake = irq_pend_i | irq_o;

  assign wsrc.ext  = ext_wake_i && ctrl_q[C_EXT_EN];
  assign wsrc.rtc  = rtc_flag && ctrl_q[C_RTC_EN];
  assign wsrc.lbat = lbat_q;
  assign hib_wake  = |wsrc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           wstat_q <= '0;
    else if (state == ST_HIB && hib_wake)  wstat_q <= wsrc;
    else if (wr_wstat)                     wstat_q <= wstat_q & ~reg_wdata_i[2:0];
  end

  lpm_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_i       (wfi_i),
    .deep_sel_i  (ctrl_q[C_DEEP]),
    .hib_req_i   (hib_req),
    .sleep_wake_i(sleep_wake),
    .hib_wake_i  (hib_wake),
    .dly_i       (dly_q),
    .state_o     (state)
  );

  lpm_retmem #(.WORDS(RET_WORDS), .DW(DW)) u_ret (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_ret),
    .addr_i (reg_addr_i[RET_AW-1:0]),
    .wdata_i(reg_wdata_i),
    .rdata_o(ret_rdata)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[REG_AW-1]) begin
      reg_rdata_o = ret_rdata;
    end else begin
      unique case (reg_addr_i)
        A_CTRL:   reg_rdata_o = DW'(ctrl_q);
        A_PERIPH: reg_rdata_o = DW'(periph_q);
        A_RTC:    reg_rdata_o = rtc_cnt;
        A_MATCH:  reg_rdata_o = rtc_match;
        A_WSTAT:  reg_rdata_o = DW'(wstat_q);
        A_IRQ:    reg_rdata_o = DW'({lbat_q, rtc_flag});
        A_DELAY:  reg_rdata_o = DW'(dly_q);
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  assign awake           = state == ST_RUN || state == ST_SLEEP || state == ST_DSLEEP;
  assign core_clk_en_o   = state == ST_RUN;
  assign mem_clk_en_o    = state == ST_RUN;
  assign sys_clk_en_o    = awake;
  assign periph_clk_en_o = awake ? periph_q : '0;
  assign periph_slow_o   = state == ST_DSLEEP && ctrl_q[C_AUTO_GT];
  assign reg_off_o       = state == ST_HIB || state == ST_HIB_WAKE;
  assign pwr_state_o     = state;
endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int NPERIPH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [REG_AW-1:0]  reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic               wfi_i,
  input logic               irq_pend_i,
  input logic               core_clk_en_o,
  input logic               mem_clk_en_o,
  input logic               sys_clk_en_o,
  input logic [NPERIPH-1:0] periph_clk_en_o,
  input logic               reg_off_o,
  input logic               irq_o,
  input logic [2:0]         pwr_state_o
);
  logic in_sleep, hib_wr;
  assign in_sleep = pwr_state_o == 3'd1 || pwr_state_o == 3'd2;
  assign hib_wr   = reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[0];

  a_r2_sleep_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sleep |-> (!core_clk_en_o && !mem_clk_en_o && sys_clk_en_o));

  a_r4_sleep_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sleep && (irq_pend_i || irq_o)) |=> (pwr_state_o == 3'd0 && core_clk_en_o));

  a_r4_wfi_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 3'd0 && wfi_i && irq_pend_i && !hib_wr) |=> pwr_state_o == 3'd0);

  a_r5_regoff_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_off_o) |-> $past(!sys_clk_en_o));

  a_r5_hib_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_off_o |-> (!sys_clk_en_o && !core_clk_en_o && periph_clk_en_o == '0));

  a_r7_release_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_off_o) |-> (sys_clk_en_o && core_clk_en_o && mem_clk_en_o));

  a_r9_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_addr_i == A_IRQ)) |=> irq_o);
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .wfi_i          (wfi_i),
  .irq_pend_i     (irq_pend_i),
  .core_clk_en_o  (core_clk_en_o),
  .mem_clk_en_o   (mem_clk_en_o),
  .sys_clk_en_o   (sys_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o),
  .reg_off_o      (reg_off_o),
  .irq_o          (irq_o),
  .pwr_state_o    (pwr_state_o)
);

// File: tb/lp_mode_ctrl_bench.sv
module lp_mode_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        wfi_i = 1'b0, irq_pend_i = 1'b0, ext_wake_i = 1'b0;
  logic        low_bat_i = 1'b0, sec_tick_i = 1'b0;
  logic        core_clk_en_o, mem_clk_en_o, sys_clk_en_o, periph_slow_o;
  logic        reg_off_o, irq_o;
  logic [7:0]  periph_clk_en_o;
  logic [2:0]  pwr_state_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] rv, cnt_now;

  always #5 clk_i = ~clk_i;

  lp_mode_ctrl u_lp_mode_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  // {deep, auto_gate, exp_slow, exp_state[2:0]}
  localparam logic [5:0] VEC [4] = '{6'b00_0_001, 6'b01_0_001, 6'b10_0_010, 6'b11_1_010};

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 state", 32'(pwr_state_o), 0);
    chk("R1 clocks", {29'b0, core_clk_en_o, mem_clk_en_o, sys_clk_en_o}, 7);
    chk("R1 periph", 32'(periph_clk_en_o), 32'hFF);
    chk("R1 regoff/irq", {30'b0, reg_off_o, irq_o}, 0);

    wr(5'd1, 32'hA5);
    foreach (VEC[i]) begin
      wr(5'd0, {29'b0, VEC[i][5], VEC[i][4], 1'b0});
      @(negedge clk_i); wfi_i = 1'b1;
      @(negedge clk_i); wfi_i = 1'b0;
      chk("R2 sleep state", 32'(pwr_state_o), 32'(VEC[i][2:0]));
      chk("R2 core/mem/sys", {29'b0, core_clk_en_o, mem_clk_en_o, sys_clk_en_o}, 1);
      chk("R3 periph in sleep", 32'(periph_clk_en_o), 32'hA5);
      chk("R3 slow select", 32'(periph_slow_o), 32'(VEC[i][3]));
      irq_pend_i = 1'b1;
      @(negedge clk_i); irq_pend_i = 1'b0;
      chk("R4 wake to run", {28'b0, pwr_state_o, core_clk_en_o}, 1);
      chk("R4 slow off", 32'(periph_slow_o), 0);
    end

    // R4 collision: wfi and pending interrupt together
    wfi_i = 1'b1; irq_pend_i = 1'b1;
    @(negedge clk_i); wfi_i = 1'b0; irq_pend_i = 1'b0;
    chk("R4 wfi collide stays run", 32'(pwr_state_o), 0);

    // R9 counter and match flag
    wr(5'd3, 5); wr(5'd2, 3);
    sec_tick_i = 1'b1; @(negedge clk_i); sec_tick_i = 1'b0;
    rd(5'd2, rv); chk("R9 count inc", rv, 4);
    chk("R9 no flag yet", 32'(irq_o), 0);
    sec_tick_i = 1'b1; @(negedge clk_i); sec_tick_i = 1'b0;
    chk("R9 flag at match", 32'(irq_o), 1);
    sec_tick_i = 1'b1; @(negedge clk_i); sec_tick_i = 1'b0;
    rd(5'd5, rv); chk("R9 flag held", rv, 1);
    wr(5'd5, 1); chk("R9 w1c", 32'(irq_o), 0);

    // R10 low battery
    low_bat_i = 1'b1; @(negedge clk_i); low_bat_i = 1'b0;
    rd(5'd5, rv); chk("R10 ignored when disabled", rv, 0);
    wr(5'd0, 32'h8);
    low_bat_i = 1'b1; @(negedge clk_i); low_bat_i = 1'b0;
    rd(5'd5, rv); chk("R10 flag set", rv, 2);
    chk("R10 irq", 32'(irq_o), 1);
    wr(5'd5, 2); chk("R10 cleared", 32'(irq_o), 0);

    // R5/R6/R7/R8/R11 hibernate with external wake
    wr(5'd6, 3);
    wr(5'd19, 32'hDEADBEEF);
    wr(5'd0, 32'h11);
    chk("R5 entry state", 32'(pwr_state_o), 3);
    chk("R5 clocks off reg on", {27'b0, sys_clk_en_o, core_clk_en_o, mem_clk_en_o, |periph_clk_en_o, reg_off_o}, 0);
    @(negedge clk_i);
    chk("R5 hib regoff", {28'b0, pwr_state_o, reg_off_o}, 9);
    rd(5'd0, rv); chk("R5 req reads 0", rv, 32'h10);
    wr(5'd21, 32'h12345678);
    rd(5'd19, rv); chk("R11 read in hib", rv, 32'hDEADBEEF);
    chk("R6 still hib", 32'(pwr_state_o), 4);
    ext_wake_i = 1'b1; @(negedge clk_i); ext_wake_i = 1'b0;
    chk("R6 ext wake", {28'b0, pwr_state_o, reg_off_o}, 11);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R7 delay hold", {27'b0, pwr_state_o, reg_off_o, sys_clk_en_o}, 6'b101_1_0);
    end
    @(negedge clk_i);
    chk("R7 release", {26'b0, pwr_state_o, reg_off_o, sys_clk_en_o, core_clk_en_o}, 6'b000_0_1_1);
    rd(5'd4, rv); chk("R8 ext source", rv, 1);
    rd(5'd21, rv); chk("R11 written in hib", rv, 32'h12345678);
    wr(5'd4, 1); rd(5'd4, rv); chk("R8 w1c", rv, 0);

    // R6 counter-match wake, tick during hibernate
    wr(5'd6, 0);
    rd(5'd2, cnt_now);
    wr(5'd3, cnt_now + 1);
    wr(5'd0, 32'h21);
    @(negedge clk_i);
    chk("R5 hib again", 32'(pwr_state_o), 4);
    sec_tick_i = 1'b1; @(negedge clk_i); sec_tick_i = 1'b0;
    chk("R9 flag in hib", {28'b0, pwr_state_o, irq_o}, 9);
    @(negedge clk_i);
    chk("R6 rtc wake", 32'(pwr_state_o), 5);
    @(negedge clk_i);
    chk("R7 zero delay", {30'b0, pwr_state_o == 3'd0, reg_off_o}, 2);
    rd(5'd4, rv); chk("R8 rtc source", rv, 2);
    wr(5'd5, 1); wr(5'd4, 7);

    // R6 low-battery wake
    wr(5'd0, 32'h9);
    @(negedge clk_i);
    low_bat_i = 1'b1; @(negedge clk_i); low_bat_i = 1'b0;
    chk("R6 lbat flag hib", 32'(pwr_state_o), 4);
    @(negedge clk_i);
    chk("R6 lbat wake", 32'(pwr_state_o), 5);
    @(negedge clk_i);
    chk("R7 run after lbat", 32'(pwr_state_o), 0);
    rd(5'd4, rv); chk("R8 lbat source", rv, 4);
    rd(5'd19, rv); chk("R11 survives", rv, 32'hDEADBEEF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule